// File: doc/BRIEF.md
# Vector Table Write Trap Counter

This block sits on the processor's data-write path, between the core and memory. It watches every store for an address inside the 32-byte exception vector table. The table sits at address 0 in the low-vector mode and at 0xFFFF0000 in the high-vector mode. Every store that lands in the table is trapped: it raises a one-cycle trap pulse, it is recorded in a small log, and it advances an attempt counter.

A limit is programmed at configuration time. While the attempts stay within that limit, the store goes on to memory. A refresh request then tells the handler which vector word changed, so that the pinned copy of the table can be unlocked, rewritten and locked again. Once the limit has been used up, further stores are still trapped and logged, but they are suppressed and never reach memory. The block acknowledges a suppressed store itself, so the processor never waits on it.

Top module: `vecTrapTop`

## Requirements
- R1: A completed write (`cpuWrValid` and `cpuWrAck` both high) whose address is inside the 32-byte table raises `trapPulse` for exactly the next cycle. The table base is 0 when `highVec` is 0 and 0xFFFF0000 when `highVec` is 1. A write outside the table never raises `trapPulse`.
- R2: Each trapped write adds one to `attemptCount`. The counter saturates at 2^CNT_W-1 and never wraps.
- R3: A trapped write is allowed when the count held before it is below the limit. An allowed write is forwarded on `memWrValid` and completes when `memWrAck` is high.
- R4: A trapped write that is not allowed keeps `memWrValid` low. In the same cycle it is acknowledged on `cpuWrAck`, whatever the state of `memWrAck`.
- R5: An allowed trapped write raises `refreshValid` in the next cycle, with `refreshIdx` equal to address bits [4:2]. A blocked write never raises `refreshValid`.
- R6: Every trapped write, allowed or blocked, is appended to a first-in first-out log of LOG_DEPTH entries. The head entry shows the address, the data and an allowed flag (1 = allowed, 0 = blocked). A pulse on `logPop` while the log is not empty removes the head.
- R7: A trapped write that arrives while the log is full and no pop is taken is dropped from the log, and it sets `logOverflow`. The flag stays set until it is cleared.
- R8: `cfgClrCnt` clears `attemptCount` and `logOverflow` in the next cycle. It takes priority over an increment in the same cycle.
- R9: After reset, the count is 0, the log is empty, the overflow flag is clear and the limit is DEF_LIMIT (4). A cycle with `cfgWe` high loads `cfgLimit` as the new limit.
- R10: A write outside the table passes to memory unchanged. It is acknowledged only when `memWrAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| highVec | input | 1 | Vector mode: 1 selects the table at 0xFFFF0000 |
| cfgWe | input | 1 | Load the limit register |
| cfgLimit | input | CNT_W | New limit value |
| cfgClrCnt | input | 1 | Clear the counter and the overflow flag |
| cpuWrValid | input | 1 | Processor write request, held until acknowledged |
| cpuWrAddr | input | ADDR_W | Processor write address |
| cpuWrData | input | DATA_W | Processor write data |
| cpuWrAck | output | 1 | Write acknowledge to the processor |
| memWrValid | output | 1 | Write request to memory |
| memWrAddr | output | ADDR_W | Write address to memory |
| memWrData | output | DATA_W | Write data to memory |
| memWrAck | input | 1 | Memory accepts the write |
| trapPulse | output | 1 | One-cycle pulse per trapped write |
| attemptCount | output | CNT_W | Saturating attempt counter |
| refreshValid | output | 1 | Request to refresh the pinned vector copy |
| refreshIdx | output | 3 | Vector word to refresh |
| logPop | input | 1 | Remove the head log entry |
| logValid | output | 1 | Log not empty |
| logAddr | output | ADDR_W | Head entry address |
| logData | output | DATA_W | Head entry data |
| logAllowed | output | 1 | Head entry was allowed |
| logOverflow | output | 1 | Sticky: a trapped write was lost from the log |

## Verification
The assertions check, on every cycle, the relations that hold at the ports at all times:
- a suppressed write is still acknowledged;
- memory never sees a write the processor did not make;
- refresh requests only come with trap pulses;
- the count only falls through a clear;
- the overflow flag stays set until it is cleared.

Only the bench scenarios can show the rest, because it depends on history. That covers the exact point where the limit is crossed, the table bases in both vector modes, log ordering and the dropping of entries when the log is full, counter saturation after hundreds of attempts, clear-versus-increment priority, and writes stalled by memory.

// File: rtl/vecTrapPkg.sv
package vecTrapPkg;
  // strobes from control to datapath for one completed write
  typedef struct packed {
    logic push;     // a trapped write completed this cycle
    logic allowed;  // that write was forwarded to memory
    logic clear;    // configuration clear request
  } trapStrobes_t;
endpackage

// File: rtl/vecTrapCtrl.sv
module vecTrapCtrl
  import vecTrapPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W = 8,
  parameter logic [ADDR_W-1:0] LOW_BASE = '0,
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000,
  parameter int DEF_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              highVec,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgLimit,
  input  logic              cfgClrCnt,
  input  logic              cpuWrValid,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic              memWrAck,
  output logic              cpuWrAck,
  output logic              memWrValid,
  output logic              trapPulse,
  output logic [CNT_W-1:0]  attemptCount,
  output trapStrobes_t      strobes
);
  localparam int TBL_BYTES = 32;
  localparam int OFS_W = $clog2(TBL_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT_RST = CNT_W'(DEF_LIMIT);

  logic [CNT_W-1:0]  countQ;
  logic [CNT_W-1:0]  limitQ;
  logic [ADDR_W-1:0] tableBase;
  logic              tableHit;
  logic              allowNow;
  logic              blockNow;
  logic              doneNow;

  always_comb begin
    tableBase = highVec ? HIGH_BASE : LOW_BASE;
    tableHit  = cpuWrAddr[ADDR_W-1:OFS_W] == tableBase[ADDR_W-1:OFS_W];
    // the count before this write must be below the limit
    allowNow  = countQ < limitQ;
    blockNow  = cpuWrValid && tableHit && !allowNow;
    memWrValid = cpuWrValid && !blockNow;
    cpuWrAck   = cpuWrValid && (blockNow || memWrAck);
    doneNow    = cpuWrValid && cpuWrAck && tableHit;
    strobes.push    = doneNow;
    strobes.allowed = allowNow;
    strobes.clear   = cfgClrCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      limitQ    <= LIMIT_RST;
      trapPulse <= 1'b0;
    end else begin
      trapPulse <= doneNow;
      if (cfgWe) limitQ <= cfgLimit;
      if (cfgClrCnt) countQ <= '0;
      else if (doneNow && countQ != CNT_MAX) countQ <= countQ + 1'b1;
    end
  end

  assign attemptCount = countQ;
endmodule

// File: rtl/vecTrapData.sv
module vecTrapData
  import vecTrapPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LOG_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              logPop,
  output logic              logValid,
  output logic [ADDR_W-1:0] logAddr,
  output logic [DATA_W-1:0] logData,
  output logic              logAllowed,
  output logic              logOverflow,
  output logic              refreshValid,
  output logic [2:0]        refreshIdx
);
  localparam int ENT_W = ADDR_W + DATA_W + 1;
  localparam int PTR_W = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam int FILL_W = $clog2(LOG_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(LOG_DEPTH - 1);
  localparam logic [FILL_W-1:0] FULL_FILL = FILL_W'(LOG_DEPTH);

  logic [ENT_W-1:0]  entryQ [LOG_DEPTH];
  logic [PTR_W-1:0]  headQ, tailQ;
  logic [FILL_W-1:0] fillQ;
  logic              isFull, popOk, pushOk, ovfSet;
  logic [ENT_W-1:0]  newEntry, headEntry;

  always_comb begin
    isFull   = fillQ == FULL_FILL;
    popOk    = logPop && fillQ != '0;
    pushOk   = strobes.push && (!isFull || popOk);
    ovfSet   = strobes.push && isFull && !popOk;
    newEntry = {wrAddr, wrData, strobes.allowed};
  end

  for (genvar e = 0; e < LOG_DEPTH; e++) begin : gEntry
    always_ff @(posedge clk) begin
      if (pushOk && tailQ == PTR_W'(e)) entryQ[e] <= newEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ        <= '0;
      tailQ        <= '0;
      fillQ        <= '0;
      logOverflow  <= 1'b0;
      refreshValid <= 1'b0;
      refreshIdx   <= '0;
    end else begin
      if (pushOk) tailQ <= (tailQ == LAST_PTR) ? '0 : tailQ + 1'b1;
      if (popOk)  headQ <= (headQ == LAST_PTR) ? '0 : headQ + 1'b1;
      case ({pushOk, popOk})
        2'b10:   fillQ <= fillQ + 1'b1;
        2'b01:   fillQ <= fillQ - 1'b1;
        default: fillQ <= fillQ;
      endcase
      if (strobes.clear) logOverflow <= 1'b0;
      else if (ovfSet)   logOverflow <= 1'b1;
      refreshValid <= strobes.push && strobes.allowed;
      if (strobes.push && strobes.allowed) refreshIdx <= wrAddr[4:2];
    end
  end

  assign headEntry  = entryQ[headQ];
  assign logValid   = fillQ != '0;
  assign logAddr    = headEntry[ENT_W-1 -: ADDR_W];
  assign logData    = headEntry[DATA_W:1];
  assign logAllowed = headEntry[0];
endmodule

// File: rtl/vecTrapTop.sv
module vecTrapTop
  import vecTrapPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W = 8,
  parameter int LOG_DEPTH = 4,
  parameter int DEF_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              highVec,
  input  logic              cfgWe,
  input  logic [CNT_W-1:0]  cfgLimit,
  input  logic              cfgClrCnt,
  input  logic              cpuWrValid,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic              cpuWrAck,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              memWrAck,
  output logic              trapPulse,
  output logic [CNT_W-1:0]  attemptCount,
  output logic              refreshValid,
  output logic [2:0]        refreshIdx,
  input  logic              logPop,
  output logic              logValid,
  output logic [ADDR_W-1:0] logAddr,
  output logic [DATA_W-1:0] logData,
  output logic              logAllowed,
  output logic              logOverflow
);
  trapStrobes_t strobes;

  vecTrapCtrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .highVec(highVec), .cfgWe(cfgWe),
    .cfgLimit(cfgLimit), .cfgClrCnt(cfgClrCnt), .cpuWrValid(cpuWrValid),
    .cpuWrAddr(cpuWrAddr), .memWrAck(memWrAck), .cpuWrAck(cpuWrAck),
    .memWrValid(memWrValid), .trapPulse(trapPulse),
    .attemptCount(attemptCount), .strobes(strobes)
  );

  vecTrapData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOG_DEPTH(LOG_DEPTH)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(cpuWrAddr),
    .wrData(cpuWrData), .logPop(logPop), .logValid(logValid),
    .logAddr(logAddr), .logData(logData), .logAllowed(logAllowed),
    .logOverflow(logOverflow), .refreshValid(refreshValid),
    .refreshIdx(refreshIdx)
  );

  assign memWrAddr = cpuWrAddr;
  assign memWrData = cpuWrData;
endmodule

// File: rtl/vecTrapChk.sv
module vecTrapChk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgClrCnt,
  input logic             cpuWrValid,
  input logic             cpuWrAck,
  input logic             memWrValid,
  input logic             trapPulse,
  input logic             refreshValid,
  input logic [CNT_W-1:0] attemptCount,
  input logic             logOverflow
);
  // R4: a write held back from memory is still acknowledged
  p_blocked_acked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrValid && !memWrValid) |-> cpuWrAck);

  // R10: memory only sees requests that the processor makes
  p_mem_follows_cpu_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> cpuWrValid);

  // R5: a refresh request only comes with a trap
  p_refresh_with_trap_r5: assert property (@(posedge clk) disable iff (!rstN)
    refreshValid |-> trapPulse);

  // R1: a trap follows a completed write
  p_trap_after_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    trapPulse |-> $past(cpuWrValid && cpuWrAck));

  // R2: the count never falls except through a clear
  p_count_monotonic_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgClrCnt |=> attemptCount >= $past(attemptCount));

  // R7: the overflow flag is sticky
  p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (logOverflow && !cfgClrCnt) |=> logOverflow);
endmodule

bind vecTrapTop vecTrapChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgClrCnt(cfgClrCnt), .cpuWrValid(cpuWrValid),
  .cpuWrAck(cpuWrAck), .memWrValid(memWrValid), .trapPulse(trapPulse),
  .refreshValid(refreshValid), .attemptCount(attemptCount),
  .logOverflow(logOverflow)
);

// File: tb/tb_vecTrapTop.sv
`timescale 1ns/1ps
module tb_vecTrapTop;
  localparam int DEPTH = 4;
  localparam int CMAX = 255;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        highVec = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgLimit = '0;
  logic        cfgClrCnt = 1'b0;
  logic        cpuWrValid = 1'b0;
  logic [31:0] cpuWrAddr = '0;
  logic [31:0] cpuWrData = '0;
  logic        memWrAck = 1'b1;
  logic        logPop = 1'b0;
  logic        cpuWrAck, memWrValid, trapPulse, refreshValid;
  logic        logValid, logAllowed, logOverflow;
  logic [31:0] memWrAddr, memWrData, logAddr, logData;
  logic [7:0]  attemptCount;
  logic [2:0]  refreshIdx;

  always #5 clk = ~clk;

  vecTrapTop dut (
    .clk(clk), .rstN(rstN), .highVec(highVec), .cfgWe(cfgWe),
    .cfgLimit(cfgLimit), .cfgClrCnt(cfgClrCnt), .cpuWrValid(cpuWrValid),
    .cpuWrAddr(cpuWrAddr), .cpuWrData(cpuWrData), .cpuWrAck(cpuWrAck),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrAck(memWrAck), .trapPulse(trapPulse), .attemptCount(attemptCount),
    .refreshValid(refreshValid), .refreshIdx(refreshIdx), .logPop(logPop),
    .logValid(logValid), .logAddr(logAddr), .logData(logData),
    .logAllowed(logAllowed), .logOverflow(logOverflow)
  );

  int nCmp = 0;
  int nBad = 0;

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int          mCount = 0;
  int          mLimit = 4;
  bit          mOvf = 0;
  bit          mTrap = 0;
  bit          mRef = 0;
  int          mRefIdx = 0;
  logic [31:0] qAddr[$];
  logic [31:0] qData[$];
  bit          qAllow[$];

  function automatic bit inTable();
    if (highVec) return cpuWrAddr >= 32'hFFFF0000 && cpuWrAddr <= 32'hFFFF001F;
    return cpuWrAddr <= 32'h1F;
  endfunction

  function automatic bit expBlock();
    return cpuWrValid && inTable() && !(mCount < mLimit);
  endfunction

  function automatic bit expAck();
    return cpuWrValid && (expBlock() || memWrAck);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCount = 0; mLimit = 4; mOvf = 0; mTrap = 0; mRef = 0;
      qAddr.delete(); qData.delete(); qAllow.delete();
    end else begin
      bit done, allow;
      done  = expAck() && inTable();
      allow = mCount < mLimit;
      mTrap = done;
      mRef  = done && allow;
      if (done && allow) mRefIdx = int'(cpuWrAddr[4:2]);
      if (logPop && qAddr.size() > 0) begin
        void'(qAddr.pop_front()); void'(qData.pop_front()); void'(qAllow.pop_front());
      end
      if (done) begin
        if (qAddr.size() < DEPTH) begin
          qAddr.push_back(cpuWrAddr); qData.push_back(cpuWrData); qAllow.push_back(allow);
        end else mOvf = 1;
      end
      if (cfgClrCnt) begin mCount = 0; mOvf = 0; end
      else if (done && mCount < CMAX) mCount++;
      if (cfgWe) mLimit = int'(cfgLimit);
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R3", "memWrValid", 64'(memWrValid), 64'(cpuWrValid && !expBlock()));
      chk("R4", "cpuWrAck", 64'(cpuWrAck), 64'(expAck()));
      chk("R1", "trapPulse", 64'(trapPulse), 64'(mTrap));
      chk("R5", "refreshValid", 64'(refreshValid), 64'(mRef));
      if (mRef) chk("R5", "refreshIdx", 64'(refreshIdx), 64'(mRefIdx));
      chk("R2", "attemptCount", 64'(attemptCount), 64'(mCount));
      chk("R6", "logValid", 64'(logValid), 64'(qAddr.size() > 0));
      if (qAddr.size() > 0) begin
        chk("R6", "logAddr", 64'(logAddr), 64'(qAddr[0]));
        chk("R6", "logData", 64'(logData), 64'(qData[0]));
        chk("R6", "logAllowed", 64'(logAllowed), 64'(qAllow[0]));
      end
      chk("R7", "logOverflow", 64'(logOverflow), 64'(mOvf));
      if (memWrValid) begin
        chk("R10", "memWrAddr", 64'(memWrAddr), 64'(cpuWrAddr));
        chk("R10", "memWrData", 64'(memWrData), 64'(cpuWrData));
      end
    end
  end

  task automatic doWrite(logic [31:0] a, logic [31:0] d);
    bit acked;
    cpuWrAddr = a; cpuWrData = d; cpuWrValid = 1'b1;
    forever begin
      @(negedge clk); acked = cpuWrAck;
      @(posedge clk); #1;
      if (acked) break;
    end
    cpuWrValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic popAll();
    logPop = 1'b1; idle(DEPTH + 1); logPop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "reset count", 64'(attemptCount), 64'd0);
    chk("R9", "reset log", 64'(logValid), 64'd0);
    chk("R9", "reset overflow", 64'(logOverflow), 64'd0);
    @(posedge clk); #1;

    // low vector mode: allowed writes and misses
    doWrite(32'h0000_0000, 32'hA0);
    doWrite(32'h0000_001C, 32'hA1);
    doWrite(32'h0000_0020, 32'hB0);   // R10 just outside the table
    doWrite(32'h0000_1000, 32'hB1);
    doWrite(32'h0000_0008, 32'hA2);
    doWrite(32'h0000_000C, 32'hA3);   // fourth attempt, still allowed
    @(negedge clk);
    chk("R3", "count at limit", 64'(attemptCount), 64'd4);
    @(posedge clk); #1;
    // fifth attempt is over the default limit of 4: blocked, and the log is full
    doWrite(32'h0000_0010, 32'hA4);
    doWrite(32'h0000_0014, 32'hA5);
    @(negedge clk);
    chk("R7", "overflow after full log", 64'(logOverflow), 64'd1);
    chk("R2", "count after blocked", 64'(attemptCount), 64'd6);
    @(posedge clk); #1;
    popAll();

    // R8: the clear resets the count and the overflow flag
    cfgClrCnt = 1'b1; idle(1); cfgClrCnt = 1'b0;
    @(negedge clk);
    chk("R8", "count cleared", 64'(attemptCount), 64'd0);
    chk("R8", "overflow cleared", 64'(logOverflow), 64'd0);
    @(posedge clk); #1;

    // high vector mode
    highVec = 1'b1;
    doWrite(32'hFFFF_0004, 32'hC0);
    doWrite(32'h0000_0004, 32'hC1);   // R1 not a table write in this mode
    doWrite(32'hFFFF_0020, 32'hC2);
    doWrite(32'hFFFF_0018, 32'hC3);
    @(negedge clk);
    chk("R1", "high mode count", 64'(attemptCount), 64'd2);
    @(posedge clk); #1;
    popAll();

    // memory stalls on a plain write and on an allowed trap
    memWrAck = 1'b0;
    fork
      doWrite(32'h0000_4000, 32'hD0);
      begin idle(3); memWrAck = 1'b1; end
    join
    memWrAck = 1'b0;
    fork
      doWrite(32'hFFFF_0000, 32'hD1);
      begin idle(3); memWrAck = 1'b1; end
    join
    // R4: a blocked write is acknowledged while memory stalls
    cfgLimit = 8'd0; cfgWe = 1'b1; idle(1); cfgWe = 1'b0;
    memWrAck = 1'b0;
    doWrite(32'hFFFF_0010, 32'hD2);
    memWrAck = 1'b1;
    popAll();

    // R8: a clear in the same cycle as an attempt wins
    highVec = 1'b0;
    cpuWrAddr = 32'h4; cpuWrData = 32'hE0; cpuWrValid = 1'b1; cfgClrCnt = 1'b1;
    idle(1);
    cpuWrValid = 1'b0; cfgClrCnt = 1'b0;
    @(negedge clk);
    chk("R8", "clear beats increment", 64'(attemptCount), 64'd0);
    @(posedge clk); #1;
    popAll();

    // R2 / R9: a large limit, then saturation
    cfgLimit = 8'd255; cfgWe = 1'b1; idle(1); cfgWe = 1'b0;
    logPop = 1'b1;
    for (int i = 0; i < 270; i++) doWrite(32'(i % 8) << 2, 32'(i));
    logPop = 1'b0;
    @(negedge clk);
    chk("R2", "saturated count", 64'(attemptCount), 64'd255);
    @(posedge clk); #1;
    idle(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule